// File: doc/BRIEF.md
# Split-Transaction Memory Slave

This block is the memory side of a single shared bus that runs a pended transaction protocol. A requester hands the block a request in one bus cycle: a command bit, an address, write data and a requester tag. The bus is then free for other traffic. Requests land in a deep input queue, so a sender can transfer even while the memory is still busy with earlier work. A service engine drains that queue one request per cycle against a small internal memory array.

A write completes entirely within its request; nothing is ever sent back for it. A read produces a completion record holding the requester tag and the read data. That record waits in an output queue. Whenever the output queue holds anything, the block raises a bus request towards an external arbiter. Each cycle in which the grant is high, the head record is driven onto the completion lines and removed.

When the input queue has no free slot, a full indication is raised at once. Senders must hold off while it is high, and any request presented anyway is dropped. This replaces retries and the bus cycles they would waste.

Top module: `split_mem_slave`

## Requirements
- R1: A synchronous active-high reset empties both queues; in the cycle after reset, `q_full`, `bus_req` and `cpl_valid` are all 0.
- R2: A read request (`req_write`=0) returns exactly one completion whose `cpl_tag` equals the request tag and whose `cpl_data` equals the data of the last write to that address accepted before the read.
- R3: A write request (`req_write`=1) updates the memory and never produces a completion or raises `bus_req` by itself.
- R4: The input queue holds 64 requests. A read is serviced only while the 8-entry output queue has a free slot. With the grant held low and only reads sent, `q_full` therefore first rises after exactly 72 accepted requests.
- R5: A request presented while `q_full` is 1 is not accepted, and it never produces a completion.
- R6: `bus_req` is 1 exactly when the output queue is non-empty. A read accepted at one clock edge raises `bus_req` after the second edge. While ungranted, the head completion stays on `cpl_tag`/`cpl_data` unchanged. Each cycle with `bus_gnt`=1 and `bus_req`=1 transfers one completion (`cpl_valid`=1).
- R7: Completions leave in the order in which their reads were accepted.
- R8: An input queue slot frees only when the engine services a request, so `q_full` clears no sooner than the second edge after a grant on a full output queue.
- R9: A request is accepted at every clock edge at which `req_valid`=1 and `q_full`=0, so back-to-back requests stream at one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present on the bus this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data (ignored for reads) |
| req_tag | input | TAG_W | Requester identifier |
| q_full | output | 1 | Input queue has no free slot |
| bus_req | output | 1 | Request to the arbiter to send a completion |
| bus_gnt | input | 1 | Grant from the arbiter |
| cpl_valid | output | 1 | Completion driven on the bus this cycle |
| cpl_tag | output | TAG_W | Tag of the requester the completion is for |
| cpl_data | output | DATA_W | Read data of the completion |

## Verification
The service engine and the grant path both act on the output queue. Under a toggling grant, a push of a new read result and the pop of the head can fall on the same edge. When that queue is full, a grant-driven pop meets an engine that is blocked, and the slot frees one edge later. The bench provokes the first case by streaming mixed reads and writes against a grant pattern that is high two cycles in three. It provokes the second by filling both queues with the grant low and then raising it. The scoreboard must see every completion in acceptance order with correct data, and `q_full` must clear exactly on the second edge after the grant.

// File: rtl/spt_pkg.sv
package spt_pkg;

  typedef enum logic {
    CMD_READ  = 1'b0,
    CMD_WRITE = 1'b1
  } cmd_e;

  // occupancy after one cycle of (possibly simultaneous) push and pop
  function automatic int occ_next(input int occ, input bit push, input bit pop);
    int n;
    n = occ;
    if (push) n = n + 1;
    if (pop)  n = n - 1;
    return n;
  endfunction

  // the engine may take the head request this cycle
  function automatic bit may_service(input bit is_write, input bit out_full);
    return is_write || !out_full;
  endfunction

endpackage

// File: rtl/spt_fifo.sv
module spt_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = store[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      count <= CW'(spt_pkg::occ_next(int'(count), do_push, do_pop));
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wp] <= wdata;
  end

  // occupancy never passes the depth (R4)
  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= DEPTH);

  // a push into a full queue leaves the occupancy unchanged or lower (R5)
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (count <= $past(count)));

endmodule

// File: rtl/spt_mem.sv
module spt_mem #(
  parameter int AW = 6,
  parameter int DW = 16,
  localparam int WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [WORDS];

  assign rdata = cells[addr];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end
endmodule

// File: rtl/spt_engine.sv
module spt_engine #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int TW = 4
) (
  input  logic          iq_empty,
  input  logic          hd_write,
  input  logic [AW-1:0] hd_addr,
  input  logic [DW-1:0] hd_wdata,
  input  logic [TW-1:0] hd_tag,
  input  logic          oq_full,
  input  logic [DW-1:0] mem_rdata,
  output logic          iq_pop,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          oq_push,
  output logic [TW+DW-1:0] oq_entry,
  output logic          svc_fire,
  output logic          svc_is_write
);
  import spt_pkg::*;

  // one request per cycle, in queue order (R2, R7)
  assign svc_is_write = (cmd_e'(hd_write) == CMD_WRITE);
  assign svc_fire     = !iq_empty && may_service(svc_is_write, oq_full);
  assign iq_pop       = svc_fire;
  assign mem_addr     = hd_addr;
  assign mem_wdata    = hd_wdata;
  assign mem_we       = svc_fire && svc_is_write;
  assign oq_push      = svc_fire && !svc_is_write;
  assign oq_entry     = {hd_tag, mem_rdata};
endmodule

// File: rtl/split_mem_slave.sv
module split_mem_slave #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 4,
  parameter int IQ_DEPTH = 64,
  parameter int OQ_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              q_full,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              cpl_valid,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic [DATA_W-1:0] cpl_data
);
  localparam int IQ_W  = 1 + ADDR_W + DATA_W + TAG_W;
  localparam int OQ_W  = TAG_W + DATA_W;
  localparam int IQ_CW = $clog2(IQ_DEPTH + 1);
  localparam int OQ_CW = $clog2(OQ_DEPTH + 1);

  // input queue
  logic [IQ_W-1:0]  iq_head;
  logic             iq_empty, iq_full, iq_pop;
  logic [IQ_CW-1:0] iq_count;

  // named events for the assertions
  logic acc_fire, svc_fire, svc_is_write, cpl_fire;

  spt_fifo #(.W(IQ_W), .DEPTH(IQ_DEPTH)) u_iq (
    .clk(clk), .rst(rst),
    .push(req_valid), .pop(iq_pop),
    .wdata({req_write, req_addr, req_wdata, req_tag}),
    .rdata(iq_head), .empty(iq_empty), .full(iq_full), .count(iq_count)
  );

  logic              hd_write;
  logic [ADDR_W-1:0] hd_addr;
  logic [DATA_W-1:0] hd_wdata;
  logic [TAG_W-1:0]  hd_tag;
  assign {hd_write, hd_addr, hd_wdata, hd_tag} = iq_head;

  // memory
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  spt_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  // output queue
  logic             oq_push, oq_empty, oq_full;
  logic [OQ_W-1:0]  oq_entry, oq_head;
  logic [OQ_CW-1:0] oq_count;

  spt_engine #(.AW(ADDR_W), .DW(DATA_W), .TW(TAG_W)) u_eng (
    .iq_empty(iq_empty), .hd_write(hd_write), .hd_addr(hd_addr),
    .hd_wdata(hd_wdata), .hd_tag(hd_tag), .oq_full(oq_full),
    .mem_rdata(mem_rdata), .iq_pop(iq_pop), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .oq_push(oq_push),
    .oq_entry(oq_entry), .svc_fire(svc_fire), .svc_is_write(svc_is_write)
  );

  spt_fifo #(.W(OQ_W), .DEPTH(OQ_DEPTH)) u_oq (
    .clk(clk), .rst(rst),
    .push(oq_push), .pop(bus_gnt),
    .wdata(oq_entry),
    .rdata(oq_head), .empty(oq_empty), .full(oq_full), .count(oq_count)
  );

  // bus side
  assign q_full    = iq_full;
  assign acc_fire  = req_valid && !iq_full;
  assign bus_req   = !oq_empty;
  assign cpl_fire  = bus_gnt && !oq_empty;
  assign cpl_valid = cpl_fire;
  assign {cpl_tag, cpl_data} = oq_head;

  // R1: reset leaves the bus side idle
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!q_full && !bus_req && !cpl_valid));

  // R3: a serviced write leaves the output queue untouched
  p_write_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (svc_fire && svc_is_write && !cpl_fire) |=> (oq_count == $past(oq_count)));

  // R5: a request against a full queue does not raise its occupancy
  p_drop_when_full_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && q_full) |=> (iq_count <= $past(iq_count)));

  // R6: grant on a pending completion transfers it
  p_grant_sends_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_gnt && bus_req) |-> cpl_valid);

  // R6: no completion without a pending bus request
  p_cpl_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |-> bus_req);

  // R6: an ungranted head is held
  p_head_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(cpl_tag) && $stable(cpl_data)));

  // R9: every accepted request raises occupancy unless one is serviced
  p_accept_grows_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_fire && !svc_fire) |=> (iq_count == $past(iq_count) + 1'b1));

endmodule

// File: tb/sim_split_mem_slave.sv
`timescale 1ns/1ps
module sim_split_mem_slave;
  localparam int AW = 6, DW = 16, TW = 4;
  localparam int IQ_N = 64, OQ_N = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [TW-1:0] req_tag = '0;
  logic bus_gnt = 1'b0;
  logic q_full, bus_req, cpl_valid;
  logic [TW-1:0] cpl_tag;
  logic [DW-1:0] cpl_data;

  split_mem_slave u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
    .q_full(q_full), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] model [1 << AW];
  logic [TW+DW-1:0] sb [$];
  bit saw_req;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare completions against the scoreboard (R2, R7)
  always begin
    @(negedge clk);
    #5;
    if (bus_req) saw_req = 1'b1;
    if (!rst && cpl_valid) begin
      if (sb.size() == 0)
        check(1'b0, "R3/R5 unexpected completion", {cpl_tag, cpl_data}, 0);
      else begin
        logic [TW+DW-1:0] e;
        e = sb.pop_front();
        check({cpl_tag, cpl_data} == e, "R2/R7 completion", {cpl_tag, cpl_data}, e);
      end
    end
  end

  // driver: one request, started and ended at a falling edge
  task automatic send(input bit wr, input int a, input int d, input int t);
    while (q_full) @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_addr = AW'(a); req_wdata = DW'(d); req_tag = TW'(t);
    if (wr) model[a] = DW'(d);
    else    sb.push_back({TW'(t), model[a]});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && sb.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2 all reads completed", sb.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(!q_full && !bus_req && !cpl_valid, "R1 reset idle", {q_full, bus_req, cpl_valid}, 0);

    // preload every word with writes (R3: no completions, grant low)
    for (int i = 0; i < (1 << AW); i++) send(1'b1, i, 16'hA000 ^ (i * 37), 0);
    repeat (4) @(negedge clk);
    check(!bus_req, "R3 writes raise no bus request", bus_req, 0);

    // R6: single read timing and head hold
    send(1'b0, 3, 0, 6);
    check(!bus_req, "R6 bus_req after first edge", bus_req, 0);
    @(negedge clk);
    check(bus_req && !cpl_valid, "R6 bus_req after second edge", {bus_req, cpl_valid}, 2'b10);
    for (int k = 0; k < 3; k++) begin
      check(cpl_tag == 4'd6 && cpl_data == model[3], "R6 head held",
            {cpl_tag, cpl_data}, {4'd6, model[3]});
      @(negedge clk);
    end
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    check(!bus_req, "R6 one grant drains one entry", bus_req, 0);

    // R3: writes with grant high never complete
    bus_gnt = 1'b1;
    saw_req = 1'b0;
    for (int i = 10; i < 16; i++) send(1'b1, i, i * 291, 2);
    repeat (10) @(negedge clk);
    check(!saw_req, "R3 no completion for writes", saw_req, 0);
    for (int i = 10; i < 16; i++) send(1'b0, i, 0, i);  // R2 read-after-write
    drain();

    // R4/R5/R8: fill both queues with grant low
    bus_gnt = 1'b0;
    begin
      int acc;
      acc = 0;
      for (int k = 0; k < 200; k++) begin
        if (q_full) break;
        req_valid = 1'b1; req_write = 1'b0;
        req_addr = AW'(k); req_tag = TW'(k);
        sb.push_back({TW'(k), model[k % (1 << AW)]});
        @(negedge clk);
        acc++;
      end
      req_valid = 1'b0;
      check(acc == IQ_N + OQ_N, "R4 accepts before q_full", acc, IQ_N + OQ_N);
    end
    // R5: requests against a full queue are dropped
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'd5; req_tag = 4'd9;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(q_full, "R5 still full after refused request", q_full, 1);
    end
    req_valid = 1'b0;
    // R8: slot frees on the second edge after the grant
    bus_gnt = 1'b1;
    @(negedge clk);
    check(q_full, "R8 q_full after first granted edge", q_full, 1);
    @(negedge clk);
    check(!q_full, "R8 q_full cleared after second edge", q_full, 0);
    drain();

    // R7/R9: back-to-back mixed stream under toggling grant
    begin
      time t0;
      fork
        begin
          t0 = $time;
          for (int i = 0; i < 48; i++)
            send(i[0], (i * 7) % (1 << AW), i * 1111, i);
          check(($time - t0) == 48 * 20, "R9 one request per cycle", $time - t0, 48 * 20);
        end
        begin
          for (int c = 0; c < 150; c++) begin
            @(negedge clk);
            bus_gnt = (c % 3 != 0);
          end
          bus_gnt = 1'b1;
        end
      join
    end
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule